// File: doc/BRIEF.md
# Dual Down-Counting Timer

This block is a bus-mapped timer with two independent 32-bit channels that count down. Each channel runs either as a periodic timer, reloading itself from a reload register each time it passes zero, or as a one-shot that stops at zero and turns itself off. Software configures the block and reads it back over a simple synchronous register bus with address, write strobe, write data, read strobe and read data.

Each channel takes its count tick from one of two sources. One is a fixed-rate reference tick-enable input, which is assumed to be already synchronous to the main clock. The other is the main clock divided by 2^N, where N is a 3-bit field set per channel. When a channel passes zero it raises an event bit in a shared status register. A bit stays set until software writes a zero to it. A registered copy of each status bit drives that channel's interrupt line.

To get a period of P ticks, software writes P-1 to both the reload and the value register and enables reload. To get a single delay, software clears the pending event, writes the delay to the value register, and enables the channel with reload off.

Top module: `dual_dn_timer`

## Requirements
- R1: After a synchronous active-low reset every register reads 0 and both interrupt lines are low.
- R2: The register map is as follows. Control is at 0x00 and status at 0x04. Channel 0 has reload at 0x10 and value at 0x14. Channel 1 has reload at 0x18 and value at 0x1C. `bus_rdata` shows the addressed register in the same cycle that `bus_rd` is high. It reads 0 for an unmapped address and 0 whenever `bus_rd` is low. The reload and value registers read back what was written to them.
- R3: The control bits for channel c are: enable at bit 2c, reload-enable at bit 2c+1, reference select at bit 11+c, and a 3-bit prescale field N at bits 19+3c upward. When reference select is 1 the channel ticks on `ref_tick`. When it is 0 the channel ticks once every 2^N main-clock cycles. An enabled channel changes its value only on a tick. With no tick it holds its value.
- R4: A control write that changes a channel's prescale field restarts that channel's prescaler from zero. The first tick after such a write comes 2^N cycles later, so the count first decrements on the 2^N-th clock edge after the write edge.
- R5: With reload enabled, a tick at value 0 raises the event and loads the reload value. The counter then keeps running, so a reload value of R gives an event every R+1 ticks.
- R6: With reload disabled, a tick at value 0 raises the event, holds the value at 0, and clears the channel's enable bit in the control register.
- R7: Status bit 0 belongs to channel 0 and bit 8 to channel 1. A new event sets its bit. Writing 0 to a bit clears it, and writing 1 leaves it unchanged. If an event and a clear land in the same cycle, the event wins.
- R8: `irq[c]` equals channel c's status bit as it was one clock earlier.
- R9: A write to a value register in the same cycle as a tick loads the written value, and that cycle's decrement or expiry is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Fixed-rate reference tick enable, synchronous to clk |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq | output | 2 | Interrupt line per channel, registered copy of the status bit |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Prescale ratios.** The divide ratio is checked at several settings on both channels. A prescaler off by one cycle leaves the count one step away from the expected value.
- **Prescaler restart.** The prescaler is deliberately left part-way through a count before the field changes. A design that does not restart it decrements early.
- **Zero crossing, both modes.** A periodic channel that reloads one tick late, or a one-shot that wraps to all ones or keeps its enable bit set, shows up in the readback.
- **Status bit semantics.** The clear-by-zero polarity is checked, along with a value write landing on a tick. A design that clears on a written one, or that decrements after the write, returns the wrong value.

// File: rtl/dual_tmr_pkg.sv
// Package: shared constants and field-position helpers for the dual timer.
// Assumes a 32-bit data path; bit positions below are fixed by the map.
package dual_tmr_pkg;

    localparam int NCH  = 2;
    localparam int PS_W = 3;
    localparam int DW   = 32;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;

    // Reload register byte offset of a channel
    function automatic logic [7:0] ofs_reload(input int ch);
        return 8'h10 + 8'(8 * ch);
    endfunction

    // Value register byte offset of a channel
    function automatic logic [7:0] ofs_value(input int ch);
        return 8'h14 + 8'(8 * ch);
    endfunction

    function automatic int en_bit(input int ch);
        return 2 * ch;
    endfunction

    function automatic int rl_bit(input int ch);
        return 2 * ch + 1;
    endfunction

    function automatic int rsel_bit(input int ch);
        return 11 + ch;
    endfunction

    function automatic int ps_lsb(input int ch);
        return 19 + PS_W * ch;
    endfunction

    function automatic int stat_bit(input int ch);
        return 8 * ch;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Module: power-of-two divider producing a one-cycle tick every 2^sel cycles.
// Assumes sel is stable except when restart is pulsed alongside its change.
module tmr_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);
    localparam int CNT_W = (1 << PS_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected ratio
    always_comb begin
        limit = (CNT_W'(1) << sel) - CNT_W'(1);
        tick  = (cnt_q >= limit);
    end

    // Free-running cycle count, cleared on restart or terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tmr_channel.sv
// Module: one down-counter with reload; flags expiry when ticked at zero.
// Assumes tick is a single-cycle enable; a value write overrides the tick.
module tmr_channel #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          reload_en,
    input  logic          tick,
    input  logic          val_wr,
    input  logic [DW-1:0] val_wdata,
    input  logic [DW-1:0] reload_val,
    output logic [DW-1:0] value,
    output logic          expire
);
    logic [DW-1:0] value_q;

    // Expiry: an accepted tick while the count sits at zero
    assign expire = enable && tick && !val_wr && (value_q == '0);
    assign value  = value_q;

    // Count register: write, then reload/hold at zero, then decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (val_wr) begin
            value_q <= val_wdata;
        end else if (enable && tick) begin
            if (value_q == '0) begin
                if (reload_en) begin
                    value_q <= reload_val;
                end
            end else begin
                value_q <= value_q - DW'(1);
            end
        end
    end

endmodule

// File: rtl/dual_dn_timer.sv
// Module: dual down-counting timer top; register file, tick selection,
// status latching and interrupt registers around two channel instances.
// Assumes ref_tick is already synchronous to clk; 32-bit data path.
module dual_dn_timer #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        irq
);
    import dual_tmr_pkg::*;

    logic            en_q    [NCH];
    logic            rl_q    [NCH];
    logic            rsel_q  [NCH];
    logic [PS_W-1:0] ps_q    [NCH];
    logic [DW-1:0]   rld_q   [NCH];
    logic [DW-1:0]   val_q   [NCH];
    logic            expire  [NCH];
    logic            tick_sel[NCH];
    logic            pre_tick[NCH];
    logic            ps_rst  [NCH];
    logic            val_wr  [NCH];
    logic            rld_wr  [NCH];
    logic            stat_q  [NCH];
    logic            ctrl_wr;
    logic            stat_wr;
    logic [DW-1:0]   ctrl_view;

    // Address decode for writes
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        stat_wr = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
        for (int c = 0; c < NCH; c++) begin
            val_wr[c] = bus_wr && (bus_addr == ADDR_W'(ofs_value(c)));
            rld_wr[c] = bus_wr && (bus_addr == ADDR_W'(ofs_reload(c)));
            ps_rst[c] = ctrl_wr && (bus_wdata[ps_lsb(c) +: PS_W] != ps_q[c]);
        end
    end

    // Per-channel prescaler, tick selection and counter
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_prescaler #(.PS_W(PS_W)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .restart(ps_rst[g]),
            .sel    (ps_q[g]),
            .tick   (pre_tick[g])
        );

        assign tick_sel[g] = rsel_q[g] ? ref_tick : pre_tick[g];

        tmr_channel #(.DW(DW)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (en_q[g]),
            .reload_en (rl_q[g]),
            .tick      (tick_sel[g]),
            .val_wr    (val_wr[g]),
            .val_wdata (bus_wdata),
            .reload_val(rld_q[g]),
            .value     (val_q[g]),
            .expire    (expire[g])
        );
    end

    // Control fields; a one-shot expiry drops its own enable unless written
    always_ff @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                en_q[c]   <= 1'b0;
                rl_q[c]   <= 1'b0;
                rsel_q[c] <= 1'b0;
                ps_q[c]   <= '0;
            end else if (ctrl_wr) begin
                en_q[c]   <= bus_wdata[en_bit(c)];
                rl_q[c]   <= bus_wdata[rl_bit(c)];
                rsel_q[c] <= bus_wdata[rsel_bit(c)];
                ps_q[c]   <= bus_wdata[ps_lsb(c) +: PS_W];
            end else if (expire[c] && !rl_q[c]) begin
                en_q[c]   <= 1'b0;
            end
        end
    end

    // Reload registers
    always_ff @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                rld_q[c] <= '0;
            end else if (rld_wr[c]) begin
                rld_q[c] <= bus_wdata;
            end
        end
    end

    // Event status: set by expiry, cleared by a written zero, set wins
    always_ff @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                stat_q[c] <= 1'b0;
            end else if (expire[c]) begin
                stat_q[c] <= 1'b1;
            end else if (stat_wr && !bus_wdata[stat_bit(c)]) begin
                stat_q[c] <= 1'b0;
            end
        end
    end

    // Interrupt lines: one-cycle registered copy of status
    always_ff @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                irq[c] <= 1'b0;
            end else begin
                irq[c] <= stat_q[c];
            end
        end
    end

    // Control register as seen by software
    always_comb begin
        ctrl_view = '0;
        for (int c = 0; c < NCH; c++) begin
            ctrl_view[en_bit(c)]            = en_q[c];
            ctrl_view[rl_bit(c)]            = rl_q[c];
            ctrl_view[rsel_bit(c)]          = rsel_q[c];
            ctrl_view[ps_lsb(c) +: PS_W]    = ps_q[c];
        end
    end

    // Read mux; zero when idle or unmapped
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(OFS_CTRL)) begin
                bus_rdata = ctrl_view;
            end
            if (bus_addr == ADDR_W'(OFS_STAT)) begin
                for (int c = 0; c < NCH; c++) begin
                    bus_rdata[stat_bit(c)] = stat_q[c];
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == ADDR_W'(ofs_reload(c))) bus_rdata = rld_q[c];
                if (bus_addr == ADDR_W'(ofs_value(c)))  bus_rdata = val_q[c];
            end
        end
    end

endmodule

// File: rtl/tmr_chk.sv
// Module: assertion checker for dual_dn_timer, attached by bind below.
// Assumes the channel count and data width from the shared package.
module tmr_chk
    import dual_tmr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input logic [31:0]   bus_rdata,
    input logic [1:0]    irq,
    input logic          stat   [NCH],
    input logic          en     [NCH],
    input logic          rl     [NCH],
    input logic          tick   [NCH],
    input logic          vwr    [NCH],
    input logic          expire [NCH],
    input logic          ctrl_wr,
    input logic [DW-1:0] val    [NCH],
    input logic [DW-1:0] rld    [NCH],
    input logic [31:0]   wdata
);
    logic armed;

    // One cycle of history after reset before $past is trusted
    always_ff @(posedge clk) armed <= rst_n;

    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 32'h0);

    for (genvar g = 0; g < NCH; g++) begin : g_p
        p_irq_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
            irq[g] == $past(stat[g]));

        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick[g] && !vwr[g]) |=> val[g] == $past(val[g]));

        p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && rl[g] && tick[g] && !vwr[g] && val[g] == '0) |=> val[g] == $past(rld[g]));

        p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && !rl[g] && tick[g] && !vwr[g] && !ctrl_wr && val[g] == '0)
            |=> (!en[g] && val[g] == '0));

        p_evt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |=> stat[g]);

        p_valwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
            vwr[g] |=> val[g] == $past(wdata));
    end

endmodule

bind dual_dn_timer tmr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .stat     (stat_q),
    .en       (en_q),
    .rl       (rl_q),
    .tick     (tick_sel),
    .vwr      (val_wr),
    .expire   (expire),
    .ctrl_wr  (ctrl_wr),
    .val      (val_q),
    .rld      (rld_q),
    .wdata    (bus_wdata)
);

// File: tb/test_dual_dn_timer.sv
// Bench: table-driven prescale checks, then directed reset/corner tests.
module test_dual_dn_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    dual_dn_timer i_dual_dn_timer (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // {channel, prescale N, start value, edges, expected value}
    localparam int unsigned VEC [6][5] = '{
        '{0, 0, 100, 10,  90},
        '{0, 1, 100, 10,  95},
        '{0, 2,  50,  9,  48},
        '{0, 5,  10, 64,   8},
        '{1, 0,   7,  5,   2},
        '{1, 4, 300, 50, 297}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        chk_rd("R1 ctrl", 8'h00, 0);
        chk_rd("R1 stat", 8'h04, 0);
        chk_rd("R1 rld0", 8'h10, 0);
        chk_rd("R1 val0", 8'h14, 0);
        chk_rd("R1 rld1", 8'h18, 0);
        chk_rd("R1 val1", 8'h1C, 0);
        chk("R1 irq", {30'b0, irq}, 0);

        // R2: readback, unmapped, idle read
        wr(8'h10, 32'hDEADBEEF);
        chk_rd("R2 rld0 readback", 8'h10, 32'hDEADBEEF);
        chk_rd("R2 unmapped", 8'h08, 0);
        bus_addr = 8'h10; #1;
        chk("R2 idle rdata", bus_rdata, 0);

        // R3: prescaled tick ratios from the table
        for (int i = 0; i < 6; i++) begin
            int ch = int'(VEC[i][0]);
            wr(8'h00, 0);
            wr(8'h14 + 8'(8 * ch), VEC[i][2]);
            wr(8'h00, (32'h1 << (2 * ch)) | (VEC[i][1] << (19 + 3 * ch)));
            step(int'(VEC[i][3]));
            chk_rd("R3 prescaled count", 8'h14 + 8'(8 * ch), VEC[i][4]);
        end

        // R5 periodic reload on ref tick
        wr(8'h00, 0);
        wr(8'h10, 3);
        wr(8'h14, 3);
        ref_tick = 1'b1;
        wr(8'h00, 32'h0000_0803);
        step(3);
        chk_rd("R5 at zero", 8'h14, 0);
        chk_rd("R5 no event yet", 8'h04, 0);
        step(1);
        chk_rd("R5 reloaded", 8'h14, 3);
        chk_rd("R7 event set", 8'h04, 32'h1);
        chk("R8 irq lags", {30'b0, irq}, 0);
        step(1);
        chk("R8 irq follows", {30'b0, irq}, 1);
        chk_rd("R5 keeps running", 8'h14, 2);

        // R3: no tick, no change
        ref_tick = 1'b0;
        step(10);
        chk_rd("R3 hold without tick", 8'h14, 2);

        // R7: write one keeps, write zero clears
        wr(8'h04, 32'hFFFF_FFFF);
        chk_rd("R7 write one no effect", 8'h04, 32'h1);
        wr(8'h04, 32'h0000_0100);
        chk_rd("R7 write zero clears", 8'h04, 0);
        step(1);
        chk("R8 irq cleared", {30'b0, irq}, 0);

        // R6 one-shot on channel 1
        wr(8'h00, 0);
        ref_tick = 1'b1;
        wr(8'h1C, 2);
        wr(8'h00, 32'h0000_1004);
        step(2);
        chk_rd("R6 reached zero", 8'h1C, 0);
        chk_rd("R6 still enabled", 8'h00, 32'h0000_1004);
        step(1);
        chk_rd("R6 event", 8'h04, 32'h100);
        chk_rd("R6 enable dropped", 8'h00, 32'h0000_1000);
        step(3);
        chk_rd("R6 holds zero", 8'h1C, 0);
        chk("R6 irq1", {30'b0, irq}, 2);

        // R9 value write beats decrement
        wr(8'h04, 0);
        wr(8'h00, 32'h1);
        wr(8'h14, 500);
        chk_rd("R9 write wins", 8'h14, 500);
        step(3);
        chk_rd("R9 then counts", 8'h14, 497);

        // R4 prescaler restart on field change
        wr(8'h00, 32'h3 << 19);
        step(5);
        wr(8'h14, 40);
        wr(8'h00, 32'h1 | (32'h2 << 19));
        step(3);
        chk_rd("R4 no early tick", 8'h14, 40);
        step(1);
        chk_rd("R4 first tick", 8'h14, 39);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule